// File: doc/BRIEF.md
# Run-Length Sample Expander

This block turns a stream of compressed capture records into plain 32-bit samples. Records arrive one byte per handshake. Each record has four bytes in a fixed order: the first channel-group byte (A), the second (B), the third (C), and then a repeat byte. The block sends the sample built from A, B and C (top byte zero) as many times as the record asks for. The repeat byte holds the run length minus one.

Before a run, a start pulse loads an output budget. Samples leave through a valid/ready port. When the budget is used up, the block clips the final record, stops taking input and raises a done flag. A counter shows how many samples have been sent since the last start. Input is held off while a record is being expanded, so at most one record is in flight.

Top module: `rle_sample_expander`

## Requirements
- R1: Record bytes are taken in the order A, B, C, repeat. The sample places A in bits 7:0, B in bits 15:8 and C in bits 23:16.
- R2: A record with repeat byte r produces r+1 identical samples, so every record yields 1 to 256 samples.
- R3: Bits 31:24 of every output sample are zero.
- R4: If a record's run is longer than the budget still left, the block sends only the remaining budget from that record.
- R5: When the budget reaches zero, done goes high. After that, in_ready and out_valid stay low, and later input bytes are neither taken nor decoded.
- R6: written equals the number of samples accepted at the output since the last start, and grows by one on each accepted sample.
- R7: in_ready is low while any sample of the current record is still waiting to be sent.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: A start pulse loads the budget, clears written and done, and throws away any partly received record. The next byte after the start is taken as byte A of a new record.
- R10: A start with a budget of zero sets done on the next cycle and produces no samples.
- R11: After reset, out_valid, in_ready, done and written are all zero until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a new decode run |
| budget_i | input | CNT_W | Output sample limit, sampled on start_i |
| in_valid_i | input | 1 | Input byte is valid |
| in_data_i | input | 8 | Input record byte |
| in_ready_o | output | 1 | Block can take an input byte |
| out_valid_o | output | 1 | Output sample is valid |
| out_data_o | output | 32 | Expanded sample |
| out_ready_i | input | 1 | Downstream can take the sample |
| done_o | output | 1 | Budget used up for this run |
| written_o | output | CNT_W | Samples sent since the last start |

## Verification
If the byte position inside a record goes wrong, the very next sample shows it: its A/B/C lanes come out rotated, or the repeat value lands in a data lane. A repeat counter that is off by one or clipped wrongly first shows when the following record's sample appears a cycle too early or too late, or when done rises with a wrong written value. A budget register that goes wrong shows at the end of the run: done rises at the wrong point, or extra input bytes are taken after the limit. For these reasons the bench checks every sample in order, the written count at each output beat, and the number of bytes taken before done.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int BYTE_W   = 8;
    localparam int GROUPS   = 3;
    localparam int REP_W    = 8;
    localparam int SAMPLE_W = 32;
    localparam int RUN_W    = REP_W + 1;
    localparam int LANES_W  = GROUPS * BYTE_W;

    typedef struct packed {
        logic [REP_W-1:0]   rep;
        logic [LANES_W-1:0] lanes;
    } rle_rec_t;
endpackage

// File: rtl/rle_record_collect.sv
module rle_record_collect
    import rle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_fire_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              rec_load_o,
    output rle_rec_t          rec_o
);
    localparam int REC_BYTES = GROUPS + 1;
    localparam int IDX_W     = $clog2(REC_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [LANES_W-1:0] lanes;
    } col_state_t;

    col_state_t state_d, state_q;
    logic       load_d;

    always_comb begin
        state_d = state_q;
        load_d  = 1'b0;
        if (start_i) begin
            state_d.idx = '0;
        end else if (byte_fire_i) begin
            if (state_q.idx == LAST_IDX) begin
                load_d      = 1'b1;
                state_d.idx = '0;
            end else begin
                state_d.lanes[int'(state_q.idx)*BYTE_W +: BYTE_W] = byte_i;
                state_d.idx = state_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rec_load_o  = load_d;
    assign rec_o.rep   = byte_i;
    assign rec_o.lanes = state_q.lanes;

    // R9: a start always brings the next byte back to lane A
    assert_restart_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q.idx == '0));
endmodule

// File: rtl/rle_expand.sv
module rle_expand
    import rle_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CNT_W-1:0]    budget_i,
    input  logic                rec_load_i,
    input  rle_rec_t            rec_i,
    input  logic                out_ready_i,
    output logic                in_ready_o,
    output logic                out_valid_o,
    output logic [SAMPLE_W-1:0] out_data_o,
    output logic                done_o,
    output logic [CNT_W-1:0]    written_o
);
    localparam int CMP_W = (CNT_W > RUN_W) ? CNT_W : RUN_W;
    localparam int PAD_W = SAMPLE_W - LANES_W;

    typedef struct packed {
        logic               active;
        logic               done;
        logic               busy;
        logic [RUN_W-1:0]   run;
        logic [CNT_W-1:0]   remain;
        logic [CNT_W-1:0]   written;
        logic [LANES_W-1:0] lanes;
    } exp_state_t;

    exp_state_t       state_d, state_q;
    logic             beat;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] run_clip;

    always_comb begin
        run_len  = RUN_W'(rec_i.rep) + 1'b1;
        run_clip = (CMP_W'(run_len) > CMP_W'(state_q.remain))
                   ? RUN_W'(state_q.remain) : run_len;
    end

    assign beat = state_q.busy && out_ready_i;

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d.active  = (budget_i != '0);
            state_d.done    = (budget_i == '0);
            state_d.busy    = 1'b0;
            state_d.run     = '0;
            state_d.remain  = budget_i;
            state_d.written = '0;
        end else if (rec_load_i) begin
            state_d.busy  = 1'b1;
            state_d.run   = run_clip;
            state_d.lanes = rec_i.lanes;
        end else if (beat) begin
            state_d.run     = state_q.run - 1'b1;
            state_d.remain  = state_q.remain - 1'b1;
            state_d.written = state_q.written + 1'b1;
            if (state_q.run == RUN_W'(1)) state_d.busy = 1'b0;
            if (state_q.remain == CNT_W'(1)) begin
                state_d.active = 1'b0;
                state_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign in_ready_o  = state_q.active && !state_q.busy;
    assign out_valid_o = state_q.busy;
    assign out_data_o  = {{PAD_W{1'b0}}, state_q.lanes};
    assign done_o      = state_q.done;
    assign written_o   = state_q.written;

    assert_written_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && state_q.busy && out_ready_i)
        |=> (state_q.written == CNT_W'($past(state_q.written) + 1'b1)));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && state_q.busy && !out_ready_i)
        |=> (state_q.busy && $stable(state_q.lanes)));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.done |-> (!state_q.busy && !state_q.active));

    assert_run_in_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.busy |-> (CMP_W'(state_q.run) <= CMP_W'(state_q.remain)));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q.written == '0 && !state_q.busy));
endmodule

// File: rtl/rle_sample_expander.sv
module rle_sample_expander
    import rle_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] budget_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic [31:0]      out_data_o,
    input  logic             out_ready_i,
    output logic             done_o,
    output logic [CNT_W-1:0] written_o
);
    logic     byte_fire;
    logic     rec_load;
    rle_rec_t rec;

    assign byte_fire = in_valid_i && in_ready_o;

    rle_record_collect u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_fire_i (byte_fire),
        .byte_i      (in_data_i),
        .rec_load_o  (rec_load),
        .rec_o       (rec)
    );

    rle_expand #(.CNT_W(CNT_W)) u_expand (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .budget_i    (budget_i),
        .rec_load_i  (rec_load),
        .rec_i       (rec),
        .out_ready_i (out_ready_i),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o),
        .done_o      (done_o),
        .written_o   (written_o)
    );

    // R7: no byte is taken while a sample is waiting at the output
    assert_no_input_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !byte_fire);
endmodule

// File: tb/rle_sample_expander_test.sv
module rle_sample_expander_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int MAX_REC    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] budget_i = '0;
    logic             in_valid_i = 1'b0;
    logic [7:0]       in_data_i = '0;
    logic             in_ready_o;
    logic             out_valid_o;
    logic [31:0]      out_data_o;
    logic             out_ready_i = 1'b0;
    logic             done_o;
    logic [CNT_W-1:0] written_o;

    rle_sample_expander #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .budget_i(budget_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .done_o(done_o), .written_o(written_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seed   = 0;
    int reps [MAX_REC];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish actual=%0d expected=<190000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_a(int r); return 8'((r*29 + seed*7 + 1) & 255); endfunction
    function automatic logic [7:0] lane_b(int r); return 8'((r*53 + seed*3 + 64) & 255); endfunction
    function automatic logic [7:0] lane_c(int r); return 8'((r*71 + seed + 128) & 255); endfunction

    function automatic logic [7:0] byte_of(int idx);
        int r = idx / 4;
        case (idx % 4)
            0: return lane_a(r);
            1: return lane_b(r);
            2: return lane_c(r);
            default: return 8'(reps[r]);
        endcase
    endfunction

    task automatic do_start(input int budget);
        @(negedge clk);
        start_i = 1'b1; budget_i = CNT_W'(budget);
        in_valid_i = 1'b0; out_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    // Budget must be reachable by the given records (sum of runs >= budget)
    task automatic run_case(input int budget, input int nrec, input int stall);
        int acc = 0, nrecs_used = 0, total;
        int byte_idx = 0, out_idx = 0, er = 0, eleft, guard = 0;
        bit prev_stall = 0;
        logic [31:0] prev_data = '0, exp;
        for (int i = 0; i < nrec; i++) begin
            if (acc >= budget) break;
            acc += reps[i] + 1;
            nrecs_used++;
        end
        total = (acc < budget) ? acc : budget;
        eleft = reps[0] + 1;
        do_start(budget);
        chk(written_o == 0 && !done_o, "R9", "written/done after start",
            {written_o, 7'b0, done_o}, 0);
        while (guard < 4000) begin
            @(negedge clk);
            if (byte_idx < nrec*4) begin
                in_valid_i = 1'b1; in_data_i = byte_of(byte_idx);
            end else begin
                in_valid_i = 1'b0;
            end
            out_ready_i = (stall != 0) ? ((guard % 3) != 2) : 1'b1;
            #1;
            if (prev_stall)
                chk(out_valid_o && out_data_o == prev_data, "R8", "held sample",
                    out_data_o, prev_data);
            if (out_valid_o)
                chk(!in_ready_o, "R7", "in_ready while expanding", in_ready_o, 0);
            if (in_valid_i && in_ready_o) byte_idx++;
            if (out_valid_o && out_ready_i) begin
                exp = {8'h00, lane_c(er), lane_b(er), lane_a(er)};
                chk(out_data_o == exp, "R1", "sample lanes", out_data_o, exp);
                chk(out_data_o[31:24] == 8'h00, "R3", "top byte", out_data_o[31:24], 0);
                chk(int'(written_o) == out_idx, "R6", "written before beat", written_o, out_idx);
                out_idx++;
                eleft--;
                if (eleft == 0 && er < MAX_REC - 1) begin
                    er++;
                    eleft = reps[er] + 1;
                end
            end
            prev_stall = out_valid_o && !out_ready_i;
            prev_data  = out_data_o;
            if (done_o) break;
            guard++;
        end
        chk(guard < 4000, "R5", "done reached", guard, 0);
        chk(out_idx == total, "R2", "samples out (R4 clip)", out_idx, total);
        chk(int'(written_o) == total, "R6", "final written", written_o, total);
        chk(byte_idx == nrecs_used*4, "R5", "bytes consumed", byte_idx, nrecs_used*4);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid_i = 1'b1; in_data_i = 8'h5A; out_ready_i = 1'b1;
            #1;
            chk(!in_ready_o && !out_valid_o && done_o, "R5", "quiet after done",
                {in_ready_o, out_valid_o, done_o}, 1);
        end
        in_valid_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < MAX_REC; i++) reps[i] = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid_o && !in_ready_o && !done_o && written_o == 0, "R11", "in reset",
            {out_valid_o, in_ready_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        in_valid_i = 1'b1; in_data_i = 8'h11;
        #1;
        chk(!out_valid_o && !in_ready_o && !done_o && written_o == 0, "R11", "idle after reset",
            {out_valid_o, in_ready_o, done_o}, 0);
        in_valid_i = 1'b0;

        // R2: every repeat value, exact-fit budget
        for (int r = 0; r < 256; r++) begin
            seed = r; reps[0] = r;
            run_case(r + 1, 1, r % 2);
        end

        // R4: clipping sweep over a multi-record stream
        reps[0] = 4; reps[1] = 9; reps[2] = 2; reps[3] = 200; reps[4] = 0;
        for (int b = 1; b <= 40; b++) begin
            seed = 300 + b;
            run_case(b, 5, b % 2);
        end
        seed = 400; run_case(150, 5, 1);
        seed = 401; run_case(219, 5, 0);
        seed = 402; run_case(220, 5, 1);

        // R10: zero budget
        do_start(0);
        chk(done_o && written_o == 0 && !in_ready_o && !out_valid_o, "R10", "zero budget",
            {done_o, in_ready_o, out_valid_o}, 4);

        // R9: partial record discarded by a new start
        do_start(50);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_valid_i = 1'b1; in_data_i = 8'hEE;
            #1;
            chk(in_ready_o, "R9", "partial byte taken", in_ready_o, 1);
        end
        in_valid_i = 1'b0;
        reps[0] = 5; reps[1] = 1;
        seed = 500; run_case(4, 2, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule